// File: doc/BRIEF.md
# Power-Management Command Port with Gated SMI

This block sits behind a byte-wide host I/O port of a power-management controller. Each byte written to its command location is decoded in the same clock edge that stores it. Two reserved codes switch the controller between legacy and ACPI operation by setting or clearing the SCI enable bit of the PM1 control register. They never produce a system management interrupt. Every other code is treated as a request for firmware service. It raises the SMI line only when the SMI enable bit in a separate configuration byte is set.

The SMI output is a level. It stays high until the SMM side pulses a clear input, so several requests arriving while one is pending merge into a single interrupt. A scratch byte next to the command location gives firmware a place to leave status. A small bank of four configuration bytes holds the SMI gate. A strap input that reports missing SMM support makes the gate byte come out of reset with its "SMM already initialised" value.

Top module: `apm_smi_port`

## Requirements
- R1: An I/O write of 0xF1 to the command location (io_addr = 0) sets sci_en on the next clock edge and does not raise smi, whatever the gate bit holds.
- R2: An I/O write of 0xF0 to the command location clears sci_en on the next clock edge and does not raise smi, whatever the gate bit holds.
- R3: An I/O write of any other value to the command location, while bit 1 of configuration byte 3 (cfg_addr = 3) is 1, drives smi high after that clock edge.
- R4: Such a write while that gate bit is 0 leaves smi low.
- R5: A command write whose value is neither 0xF0 nor 0xF1 leaves sci_en unchanged.
- R6: Once high, smi stays high until smi_clr is sampled high, and then falls on that edge. Further qualifying commands while it is high keep it high. If smi_clr and a qualifying command arrive in the same cycle, smi ends high.
- R7: While rst_n is low at a clock edge, sci_en, smi, the command byte, the scratch byte and configuration bytes 0 to 3 are cleared. The exception is byte 3, which resets to 0x02 when smm_strap_dis is 1.
- R8: io_rdata returns the last command byte at io_addr = 0 and the scratch byte at io_addr = 1. A write to io_addr = 1 updates only the scratch byte and is never decoded as a command.
- R9: cfg_wr writes cfg_wdata into configuration byte cfg_addr (0 to 3), and cfg_rdata returns byte cfg_addr. A command write is gated by the bit value held before a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_strap_dis | input | 1 | Strap: SMM support absent, gate byte resets to 0x02 |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | 1 | 0 = command byte, 1 = scratch byte |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read-back of the byte selected by io_addr |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration byte select (byte 3 holds the SMI gate) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte selected by cfg_addr |
| smi_clr | input | 1 | Clear request from the SMM side |
| sci_en | output | 1 | PM1 control SCI enable (ACPI mode) |
| smi | output | 1 | System management interrupt, level until cleared |

## Verification
Setting and clearing the SMI level can meet in one cycle. The bench drives a qualifying command and smi_clr on the same edge and expects smi to be high afterwards. A second collision is between a command and a write to the gate byte. The bench enables the gate in the same cycle as a command and expects no SMI, because the gate value before the write decides. It then expects the next command to raise SMI, which shows that the new gate value took effect.

// File: rtl/apm_pkg.sv
// Package: shared codes and types for the power-management command port.
// Assumes 8-bit command bytes; the two reserved codes are fixed values.
package apm_pkg;
    localparam logic [7:0] CODE_ACPI_ON  = 8'hF1;
    localparam logic [7:0] CODE_ACPI_OFF = 8'hF0;
    localparam logic [7:0] SMM_DONE_VAL  = 8'h02;

    // Classification of one host write to the command location
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_ON   = 2'd1,
        REQ_OFF  = 2'd2,
        REQ_TRAP = 2'd3
    } cmd_req_e;
endpackage

// File: rtl/apm_cfg_bank.sv
// Module: bank of configuration bytes, one of which carries the SMI gate bit.
// Assumes synchronous active-low reset; the strap selects the gate byte's
// reset value (SMM already initialised when SMM support is absent).
module apm_cfg_bank #(
    parameter int NBYTES    = 4,
    parameter int GATE_BYTE = 3,
    parameter int GATE_BIT  = 1,
    localparam int AW       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_dis,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          gate
);
    import apm_pkg::*;

    logic [7:0] byte_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam bit IS_GATE = (i == GATE_BYTE);
        // Hold one configuration byte; reset value depends on strap for the gate byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[i] <= (IS_GATE && strap_dis) ? SMM_DONE_VAL : 8'h00;
            else if (wr && addr == AW'(i))
                byte_q[i] <= wdata;
        end
    end

    // Read mux over the bank
    always_comb rdata = byte_q[addr];

    // Gate bit comes from the stored value, before any same-cycle write
    always_comb gate = byte_q[GATE_BYTE][GATE_BIT];
endmodule

// File: rtl/apm_cmd_regs.sv
// Module: command and scratch bytes on the host I/O port, plus decode of
// each command write into a request class. Assumes a single-cycle write strobe.
module apm_cmd_regs (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output apm_pkg::cmd_req_e req
);
    import apm_pkg::*;

    logic [7:0] cmd_q;
    logic [7:0] scratch_q;
    logic       cmd_wr;

    always_comb cmd_wr = wr && !addr;

    // Store the last command byte
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= 8'h00;
        else if (cmd_wr) cmd_q <= wdata;
    end

    // Store the free scratch byte
    always_ff @(posedge clk) begin
        if (!rst_n)          scratch_q <= 8'h00;
        else if (wr && addr) scratch_q <= wdata;
    end

    // Classify the incoming command write
    always_comb begin
        if (!cmd_wr)                     req = REQ_NONE;
        else if (wdata == CODE_ACPI_ON)  req = REQ_ON;
        else if (wdata == CODE_ACPI_OFF) req = REQ_OFF;
        else                             req = REQ_TRAP;
    end

    // Read-back mux
    always_comb rdata = addr ? scratch_q : cmd_q;
endmodule

// File: rtl/apm_event_ctl.sv
// Module: SCI enable bit and the latched SMI level. Assumes requests arrive
// already classified; a new trap request wins over a same-cycle clear.
module apm_event_ctl (
    input  logic              clk,
    input  logic              rst_n,
    input  apm_pkg::cmd_req_e req,
    input  logic              gate,
    input  logic              smi_clr,
    output logic              sci_en,
    output logic              smi
);
    import apm_pkg::*;

    logic sci_q;
    logic smi_q;
    logic smi_set;

    always_comb smi_set = (req == REQ_TRAP) && gate;

    // Track ACPI mode from the two reserved codes only
    always_ff @(posedge clk) begin
        if (!rst_n)              sci_q <= 1'b0;
        else if (req == REQ_ON)  sci_q <= 1'b1;
        else if (req == REQ_OFF) sci_q <= 1'b0;
    end

    // Hold SMI until cleared; a set in the same cycle takes priority
    always_ff @(posedge clk) begin
        if (!rst_n)       smi_q <= 1'b0;
        else if (smi_set) smi_q <= 1'b1;
        else if (smi_clr) smi_q <= 1'b0;
    end

    always_comb sci_en = sci_q;
    always_comb smi    = smi_q;
endmodule

// File: rtl/apm_smi_port.sv
// Module: top of the power-management command port. Joins the host I/O
// registers, the configuration bank and the event control. Assumes a
// synchronous active-low reset and one clock domain.
module apm_smi_port #(
    parameter int CFG_BYTES = 4,
    parameter int GATE_BYTE = 3,
    parameter int GATE_BIT  = 1,
    localparam int CFG_AW   = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_strap_dis,
    input  logic              io_wr,
    input  logic              io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smi_clr,
    output logic              sci_en,
    output logic              smi
);
    import apm_pkg::*;

    cmd_req_e req;
    logic     smi_gate;

    apm_cmd_regs u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (io_wr),
        .addr  (io_addr),
        .wdata (io_wdata),
        .rdata (io_rdata),
        .req   (req)
    );

    apm_cfg_bank #(
        .NBYTES    (CFG_BYTES),
        .GATE_BYTE (GATE_BYTE),
        .GATE_BIT  (GATE_BIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_dis (smm_strap_dis),
        .wr        (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .gate      (smi_gate)
    );

    apm_event_ctl u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gate    (smi_gate),
        .smi_clr (smi_clr),
        .sci_en  (sci_en),
        .smi     (smi)
    );
endmodule

// File: rtl/apm_smi_port_chk.sv
// Module: property checker for apm_smi_port, attached by bind. Watches the
// host write port, the gate bit from the configuration bank and the outputs.
module apm_smi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_wr,
    input logic       io_addr,
    input logic [7:0] io_wdata,
    input logic       smi_gate,
    input logic       smi_clr,
    input logic       sci_en,
    input logic       smi
);
    logic cmd_w;
    logic rsvd;
    always_comb cmd_w = io_wr && !io_addr;
    always_comb rsvd  = (io_wdata == 8'hF1) || (io_wdata == 8'hF0);

    assert_acpi_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && io_wdata == 8'hF1) |=> sci_en);
    assert_acpi_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && io_wdata == 8'hF0) |=> !sci_en);
    assert_rsvd_no_smi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && rsvd && !smi) |=> !smi);
    assert_trap_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !rsvd && smi_gate) |=> smi);
    assert_gated_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !rsvd && !smi_gate && !smi) |=> !smi);
    assert_sci_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_w && rsvd)) |=> $stable(sci_en));
    assert_smi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi && !smi_clr) |=> smi);
    assert_smi_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_clr && !(cmd_w && !rsvd && smi_gate)) |=> !smi);
endmodule

bind apm_smi_port apm_smi_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .smi_gate (smi_gate),
    .smi_clr  (smi_clr),
    .sci_en   (sci_en),
    .smi      (smi)
);

// File: tb/test_apm_smi_port.sv
module test_apm_smi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smm_strap_dis = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_addr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       smi_clr = 1'b0;
    logic       sci_en;
    logic       smi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    apm_smi_port i_apm_smi_port (
        .clk(clk), .rst_n(rst_n), .smm_strap_dis(smm_strap_dis),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .smi_clr(smi_clr), .sci_en(sci_en), .smi(smi)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; smm_strap_dis = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cmd_write(input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 1'b0; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        smi_clr = 1'b1;
        @(negedge clk);
        smi_clr = 1'b0;
    endtask

    task automatic rd_io(input logic a, output logic [7:0] v);
        io_addr = a; #1; v = io_rdata;
    endtask

    task automatic rd_cfg(input logic [1:0] a, output logic [7:0] v);
        cfg_addr = a; #1; v = cfg_rdata;
    endtask

    // R7: reset state, with and without the strap
    task automatic t_reset(input logic strap);
        logic [7:0] v;
        do_reset(strap);
        chk("R7 sci_en after reset", 8'(sci_en), 8'h00);
        chk("R7 smi after reset", 8'(smi), 8'h00);
        rd_io(1'b0, v); chk("R7 cmd byte after reset", v, 8'h00);
        rd_io(1'b1, v); chk("R7 scratch after reset", v, 8'h00);
        for (int i = 0; i < 3; i++) begin
            rd_cfg(2'(i), v); chk("R7 cfg byte after reset", v, 8'h00);
        end
        rd_cfg(2'd3, v); chk("R7 gate byte after reset", v, strap ? 8'h02 : 8'h00);
    endtask

    // R1, R8: 0xF1 enables ACPI mode, no SMI, readable back
    task automatic t_acpi_on();
        logic [7:0] v;
        cmd_write(8'hF1);
        chk("R1 sci_en set", 8'(sci_en), 8'h01);
        chk("R1 no smi", 8'(smi), 8'h00);
        rd_io(1'b0, v); chk("R8 cmd readback", v, 8'hF1);
    endtask

    // R4, R5: other code with gate off leaves both outputs alone
    task automatic t_gate_off();
        cmd_write(8'h42);
        chk("R5 sci_en kept", 8'(sci_en), 8'h01);
        chk("R4 no smi gate off", 8'(smi), 8'h00);
    endtask

    // R2, R1: reserved codes give no SMI even with the gate on
    task automatic t_rsvd_gated();
        cfg_write(2'd3, 8'h02);
        cmd_write(8'hF0);
        chk("R2 sci_en cleared", 8'(sci_en), 8'h00);
        chk("R2 no smi gate on", 8'(smi), 8'h00);
        cmd_write(8'hF1);
        chk("R1 no smi gate on", 8'(smi), 8'h00);
        chk("R1 sci_en set again", 8'(sci_en), 8'h01);
        cmd_write(8'hF0);
    endtask

    // R3, R5, R6: SMI raised, held across repeats, cleared by smi_clr
    task automatic t_smi_cycle();
        cmd_write(8'h55);
        chk("R3 smi raised", 8'(smi), 8'h01);
        chk("R5 sci_en kept on trap", 8'(sci_en), 8'h00);
        cmd_write(8'h66);
        chk("R6 smi held on repeat", 8'(smi), 8'h01);
        @(negedge clk);
        chk("R6 smi held idle", 8'(smi), 8'h01);
        clr_pulse();
        chk("R6 smi cleared", 8'(smi), 8'h00);
        @(negedge clk);
        chk("R6 smi stays low", 8'(smi), 8'h00);
    endtask

    // R6: set and clear in the same cycle, set wins
    task automatic t_coincide();
        @(negedge clk);
        io_wr = 1'b1; io_addr = 1'b0; io_wdata = 8'h77; smi_clr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; smi_clr = 1'b0;
        chk("R6 set wins over clear", 8'(smi), 8'h01);
        clr_pulse();
        chk("R6 clear after collision", 8'(smi), 8'h00);
    endtask

    // R9: gate sampled before a same-cycle config write
    task automatic t_gate_old();
        logic [7:0] v;
        cfg_write(2'd3, 8'h00);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h02;
        io_wr = 1'b1; io_addr = 1'b0; io_wdata = 8'h10;
        @(negedge clk);
        cfg_wr = 1'b0; io_wr = 1'b0;
        chk("R9 old gate used", 8'(smi), 8'h00);
        rd_cfg(2'd3, v); chk("R9 gate byte written", v, 8'h02);
        cmd_write(8'h10);
        chk("R9 new gate used", 8'(smi), 8'h01);
        clr_pulse();
    endtask

    // R8: scratch writes are not commands
    task automatic t_scratch();
        logic [7:0] v;
        @(negedge clk);
        io_wr = 1'b1; io_addr = 1'b1; io_wdata = 8'hF1;
        @(negedge clk);
        io_wr = 1'b0;
        chk("R8 scratch no sci change", 8'(sci_en), 8'h00);
        chk("R8 scratch no smi", 8'(smi), 8'h00);
        rd_io(1'b1, v); chk("R8 scratch readback", v, 8'hF1);
        rd_io(1'b0, v); chk("R8 cmd byte unchanged", v, 8'h10);
    endtask

    // R9, R4: config bytes read/write, clearing the gate stops SMI
    task automatic t_cfg_rw();
        logic [7:0] v;
        cfg_write(2'd0, 8'h11);
        cfg_write(2'd1, 8'h22);
        cfg_write(2'd2, 8'h33);
        cfg_write(2'd3, 8'hFD);
        rd_cfg(2'd0, v); chk("R9 cfg0", v, 8'h11);
        rd_cfg(2'd1, v); chk("R9 cfg1", v, 8'h22);
        rd_cfg(2'd2, v); chk("R9 cfg2", v, 8'h33);
        rd_cfg(2'd3, v); chk("R9 cfg3", v, 8'hFD);
        cmd_write(8'h99);
        chk("R4 gate bit clear no smi", 8'(smi), 8'h00);
    endtask

    // R7: strap-forced gate lets a command raise SMI straight after reset
    task automatic t_strap();
        t_reset(1'b1);
        cmd_write(8'h33);
        chk("R7 strap gate raises smi", 8'(smi), 8'h01);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset(1'b0);
        t_acpi_on();
        t_gate_off();
        t_rsvd_gated();
        t_smi_cycle();
        t_coincide();
        t_gate_old();
        t_scratch();
        t_cfg_rw();
        t_strap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule